// File: doc/BRIEF.md
# Dual-rail four-phase channel link

This block carries an N-bit word across a return-to-zero channel in which every data bit travels on two wires, one that rises for a one and one that rises for a zero, and a single acknowledge wire flows back. The transmit half takes a plain binary word with a request. It raises the rail pairs over one or more clock cycles, in an order set by a seeded pseudo-random sequence. It holds the complete code until acknowledge rises, then lowers the pairs again, also spread over cycles.

The receive half finds completion from the rail values alone. A word counts as complete only when every pair has exactly one wire high, and as cleared only when every wire is low. It captures and decodes a complete word, raises acknowledge and gives a one-cycle done pulse. It lowers acknowledge again only after the channel is fully cleared. A pair with both wires high is neither complete nor cleared, and it sets an error flag that stays set until reset.

Both halves face the chip boundary with their rails and acknowledge as separate ports. In normal use the transmit rails feed the receive rails, and the receive acknowledge feeds the transmit acknowledge. Every decision is taken on the rising clock edge.

Top module: `dr_link`

## Requirements
- R1: After reset the transmit rails are all low, acknowledge is low, done and error are low, the transmit side is ready, the cleared flag is high and the complete flag is low.
- R2: For a sent word w, a finished code on the transmit rails has true rail i equal to w[i] and false rail i equal to the inverse of w[i]. No transmit pair ever has both wires high.
- R3: The cleared flag is high exactly when every true and every false rail at the receiver is low.
- R4: The complete flag is high exactly when every pair has exactly one wire high. A word with only some pairs raised reads as not complete.
- R5: A word with only some pairs lowered, on its way back to zero, reads as not cleared, and acknowledge stays high while it is present.
- R6: A pair with both wires high makes both the complete and the cleared flags low. The error flag is high from the next clock edge and stays high until reset, including after the channel returns to zero.
- R7: While acknowledge is low and the rails are complete, the next edge captures the decoded word (bit i = true rail i), raises acknowledge and pulses done for exactly one cycle.
- R8: While acknowledge is high, it falls only on the edge after the rails are fully cleared, and no new capture happens.
- R9: The transmit side accepts a request only while it is idle and acknowledge is low. It holds the finished code unchanged until acknowledge is high, then returns every rail to low. It is not ready again until acknowledge has fallen.
- R10: The transmit side raises pairs monotonically and lowers them monotonically, a seeded subset per cycle with at least one pair per cycle. Intermediate codes therefore appear on the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_word | input | WIDTH | Binary word to transmit |
| snd_req | input | 1 | Request to transmit snd_word |
| snd_ready | output | 1 | Transmit side idle with acknowledge low |
| snd_rail_t | output | WIDTH | Transmit true rails |
| snd_rail_f | output | WIDTH | Transmit false rails |
| snd_ack | input | 1 | Acknowledge seen by the transmit side |
| rcv_rail_t | input | WIDTH | Receive true rails |
| rcv_rail_f | input | WIDTH | Receive false rails |
| rcv_ack | output | 1 | Acknowledge driven by the receive side |
| rcv_word | output | WIDTH | Last captured decoded word |
| rcv_done | output | 1 | One-cycle pulse on each capture |
| rcv_err | output | 1 | Sticky flag for a pair with both wires high |
| rcv_complete | output | 1 | Every pair at the receiver has exactly one wire high |
| rcv_clear | output | 1 | Every receive rail is low |

## Verification
The last missing pair of a word and a pair with both wires high can reach the receiver in the same cycle. Capture and error detection then compete for that edge. The bench provokes this by driving the receive rails directly with a code in which every pair but one is legal and the remaining pair is shorted high. It expects no done pulse, acknowledge held low and the error flag set on the next edge. It then sends a clean word and expects a normal capture with the error flag still set.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_RISE = 2'd1,
    TX_HOLD = 2'd2,
    TX_FALL = 2'd3
  } tx_state_e;

  localparam int unsigned SEQ_W = 16;

  // Fibonacci shift sequence, taps 16,14,13,11
  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/dr_tx.sv
module dr_tx
  import dr_link_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word,
  input  logic             req,
  input  logic             ack,
  output logic             ready,
  output logic [WIDTH-1:0] rail_t,
  output logic [WIDTH-1:0] rail_f,
  output logic             rising,
  output logic             falling,
  output logic             holding
);

  localparam int unsigned SPAN = (WIDTH > SEQ_W) ? WIDTH : SEQ_W;
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // fold the sequence state onto the pair positions
  function automatic logic [WIDTH-1:0] spread(input logic [SEQ_W-1:0] s);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int k = 0; k < int'(SPAN); k++) begin
      m[k % WIDTH] = m[k % WIDTH] ^ s[k % SEQ_W];
    end
    return m;
  endfunction

  // subset of candidates chosen by mask, never empty when candidates exist
  function automatic logic [WIDTH-1:0] pick(input logic [WIDTH-1:0] cand,
                                            input logic [WIDTH-1:0] mask);
    logic [WIDTH-1:0] sel;
    sel = cand & mask;
    if (sel == '0) sel = cand & (~cand + 1'b1);
    return sel;
  endfunction

  tx_state_e        state_q;
  logic [WIDTH-1:0] word_q;
  logic [SEQ_W-1:0] seq_q;
  logic [WIDTH-1:0] up_q;
  logic [WIDTH-1:0] sel;

  assign up_q = rail_t | rail_f;

  always_comb begin
    if (state_q == TX_FALL) sel = pick(up_q, spread(seq_q));
    else                    sel = pick(~up_q, spread(seq_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      word_q  <= '0;
      seq_q   <= SEED;
      rail_t  <= '0;
      rail_f  <= '0;
    end else begin
      seq_q <= seq_next(seq_q);
      case (state_q)
        TX_IDLE: begin
          if (req && !ack) begin
            word_q  <= word;
            state_q <= TX_RISE;
          end
        end
        TX_RISE: begin
          rail_t <= rail_t | (sel & word_q);
          rail_f <= rail_f | (sel & ~word_q);
          if ((up_q | sel) == ALL_ONES) state_q <= TX_HOLD;
        end
        TX_HOLD: begin
          if (ack) state_q <= TX_FALL;
        end
        TX_FALL: begin
          rail_t <= rail_t & ~sel;
          rail_f <= rail_f & ~sel;
          if ((up_q & ~sel) == '0) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign ready   = (state_q == TX_IDLE) && !ack;
  assign rising  = (state_q == TX_RISE);
  assign falling = (state_q == TX_FALL);
  assign holding = (state_q == TX_HOLD);

endmodule

// File: rtl/dr_detect.sv
module dr_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             complete,
  output logic             clear,
  output logic             bad,
  output logic [WIDTH-1:0] word
);

  function automatic logic all_pairs_single(input logic [WIDTH-1:0] t,
                                            input logic [WIDTH-1:0] f);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(WIDTH); i++) begin
      ok = ok & (t[i] != f[i]);
    end
    return ok;
  endfunction

  function automatic logic all_low(input logic [WIDTH-1:0] t,
                                   input logic [WIDTH-1:0] f);
    return (t == '0) && (f == '0);
  endfunction

  function automatic logic any_shorted(input logic [WIDTH-1:0] t,
                                       input logic [WIDTH-1:0] f);
    return |(t & f);
  endfunction

  assign complete = all_pairs_single(rail_t, rail_f);
  assign clear    = all_low(rail_t, rail_f);
  assign bad      = any_shorted(rail_t, rail_f);
  assign word     = rail_t;

endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             ack,
  output logic [WIDTH-1:0] word,
  output logic             done,
  output logic             err,
  output logic             complete,
  output logic             clear,
  output logic             bad
);

  logic [WIDTH-1:0] decoded;
  logic             take;
  logic             release_ack;

  dr_detect #(.WIDTH(WIDTH)) u_detect (
    .rail_t   (rail_t),
    .rail_f   (rail_f),
    .complete (complete),
    .clear    (clear),
    .bad      (bad),
    .word     (decoded)
  );

  assign take        = !ack && complete;
  assign release_ack = ack && clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      word <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= take;
      err  <= err | bad;
      if (take) begin
        word <= decoded;
        ack  <= 1'b1;
      end else if (release_ack) begin
        ack <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dr_link.sv
module dr_link
  import dr_link_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] snd_word,
  input  logic             snd_req,
  output logic             snd_ready,
  output logic [WIDTH-1:0] snd_rail_t,
  output logic [WIDTH-1:0] snd_rail_f,
  input  logic             snd_ack,
  input  logic [WIDTH-1:0] rcv_rail_t,
  input  logic [WIDTH-1:0] rcv_rail_f,
  output logic             rcv_ack,
  output logic [WIDTH-1:0] rcv_word,
  output logic             rcv_done,
  output logic             rcv_err,
  output logic             rcv_complete,
  output logic             rcv_clear
);

  // internal events brought out for the checker
  logic tx_rising;
  logic tx_falling;
  logic tx_holding;
  logic rx_bad;

  dr_tx #(.WIDTH(WIDTH), .SEED(SEED)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .word    (snd_word),
    .req     (snd_req),
    .ack     (snd_ack),
    .ready   (snd_ready),
    .rail_t  (snd_rail_t),
    .rail_f  (snd_rail_f),
    .rising  (tx_rising),
    .falling (tx_falling),
    .holding (tx_holding)
  );

  dr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_t   (rcv_rail_t),
    .rail_f   (rcv_rail_f),
    .ack      (rcv_ack),
    .word     (rcv_word),
    .done     (rcv_done),
    .err      (rcv_err),
    .complete (rcv_complete),
    .clear    (rcv_clear),
    .bad      (rx_bad)
  );

endmodule

// File: rtl/dr_link_checker.sv
module dr_link_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snd_ready,
  input logic             snd_ack,
  input logic [WIDTH-1:0] snd_rail_t,
  input logic [WIDTH-1:0] snd_rail_f,
  input logic             rcv_ack,
  input logic             rcv_done,
  input logic             rcv_err,
  input logic             rcv_complete,
  input logic             rcv_clear,
  input logic             tx_rising,
  input logic             tx_falling,
  input logic             tx_holding,
  input logic             rx_bad
);

  logic [WIDTH-1:0] tx_up;
  assign tx_up = snd_rail_t | snd_rail_f;

  p_tx_no_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_rail_t & snd_rail_f) == '0);

  p_bad_excludes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |-> (!rcv_complete && !rcv_clear));

  p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |=> rcv_err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_err |=> rcv_err);

  p_ack_rise_on_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcv_ack) |-> ($past(rcv_complete) && rcv_done));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_done |=> !rcv_done);

  p_ack_fall_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rcv_ack) |-> $past(rcv_clear));

  p_ready_ack_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snd_ready |-> !snd_ack);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_holding && !snd_ack) |=> ($stable(snd_rail_t) && $stable(snd_rail_f)));

  p_rise_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rising |=> ((tx_up & $past(tx_up)) == $past(tx_up)) && (tx_up != $past(tx_up)));

  p_fall_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_falling |=> ((tx_up | $past(tx_up)) == $past(tx_up)) && (tx_up != $past(tx_up)));

endmodule

bind dr_link dr_link_checker #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snd_ready    (snd_ready),
  .snd_ack      (snd_ack),
  .snd_rail_t   (snd_rail_t),
  .snd_rail_f   (snd_rail_f),
  .rcv_ack      (rcv_ack),
  .rcv_done     (rcv_done),
  .rcv_err      (rcv_err),
  .rcv_complete (rcv_complete),
  .rcv_clear    (rcv_clear),
  .tx_rising    (tx_rising),
  .tx_falling   (tx_falling),
  .tx_holding   (tx_holding),
  .rx_bad       (rx_bad)
);

// File: tb/dr_link_bench.sv
module dr_link_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] snd_word = '0;
  logic         snd_req = 1'b0;
  logic         snd_ready;
  logic [W-1:0] snd_rail_t, snd_rail_f;
  logic         snd_ack;
  logic [W-1:0] rcv_rail_t, rcv_rail_f;
  logic         rcv_ack;
  logic [W-1:0] rcv_word;
  logic         rcv_done, rcv_err, rcv_complete, rcv_clear;

  logic         inject = 1'b0;
  logic [W-1:0] inj_t = '0, inj_f = '0;

  int checks = 0;
  int errors = 0;
  int partials = 0;
  int cycles = 0;
  logic [W-1:0] expq[$];

  always #2 clk = ~clk;

  assign rcv_rail_t = inject ? inj_t : snd_rail_t;
  assign rcv_rail_f = inject ? inj_f : snd_rail_f;
  assign snd_ack    = rcv_ack;

  dr_link #(.WIDTH(W)) u_dr_link (
    .clk(clk), .rst_n(rst_n),
    .snd_word(snd_word), .snd_req(snd_req), .snd_ready(snd_ready),
    .snd_rail_t(snd_rail_t), .snd_rail_f(snd_rail_f), .snd_ack(snd_ack),
    .rcv_rail_t(rcv_rail_t), .rcv_rail_f(rcv_rail_f), .rcv_ack(rcv_ack),
    .rcv_word(rcv_word), .rcv_done(rcv_done), .rcv_err(rcv_err),
    .rcv_complete(rcv_complete), .rcv_clear(rcv_clear)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic code_full(input logic [W-1:0] t, input logic [W-1:0] f);
    for (int i = 0; i < W; i++) if (t[i] == f[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic code_empty(input logic [W-1:0] t, input logic [W-1:0] f);
    return ((t | f) == '0);
  endfunction

  task automatic send(input logic [W-1:0] w);
    @(negedge clk);
    while (!snd_ready) @(negedge clk);
    snd_word = w;
    snd_req  = 1'b1;
    expq.push_back(w);
    @(negedge clk);
    snd_req = 1'b0;
  endtask

  // scoreboard monitor and channel observer
  always @(negedge clk) begin
    if (rst_n && !inject) begin
      if (rcv_done) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected capture", rcv_word, 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(rcv_word == e, "R7 captured word", rcv_word, e);
        end
      end
      if (code_full(snd_rail_t, snd_rail_f))
        chk(snd_rail_t == ~snd_rail_f, "R2 rail pair inverse", snd_rail_f, ~snd_rail_t);
      chk(rcv_complete == code_full(rcv_rail_t, rcv_rail_f), "R4 complete flag",
          rcv_complete, code_full(rcv_rail_t, rcv_rail_f));
      chk(rcv_clear == code_empty(rcv_rail_t, rcv_rail_f), "R3 cleared flag",
          rcv_clear, code_empty(rcv_rail_t, rcv_rail_f));
      if (!code_full(snd_rail_t, snd_rail_f) && !code_empty(snd_rail_t, snd_rail_f))
        partials++;
      if (snd_ready) chk(!snd_ack, "R9 ready while ack high", snd_ack, 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic reset_and_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(snd_rail_t == '0 && snd_rail_f == '0, "R1 rails low", {snd_rail_t, snd_rail_f}, 0);
    chk(!rcv_ack && !rcv_done && !rcv_err, "R1 ack/done/err low",
        {rcv_ack, rcv_done, rcv_err}, 0);
    chk(snd_ready && rcv_clear && !rcv_complete, "R1 ready/cleared",
        {snd_ready, rcv_clear, rcv_complete}, 3'b110);
  endtask

  initial begin
    reset_and_check();

    // loopback traffic through the scoreboard (R2, R7, R9, R10)
    send(8'h00); send(8'hFF); send(8'hA5); send(8'h5A);
    send(8'h01); send(8'h80);
    for (int k = 0; k < 20; k++) send(8'(k * 37 + 11));
    while (expq.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(snd_rail_t == '0 && !rcv_ack && snd_ready, "R9 return to zero",
        {snd_rail_t, rcv_ack, snd_ready}, 1);
    chk(partials > 0, "R10 intermediate codes seen", partials, 1);

    // direct drive of the receive rails
    inject = 1'b1;
    inj_t = 8'h03; inj_f = 8'h00;                 // two pairs raised
    #1;
    chk(!rcv_complete && !rcv_clear, "R4 partial rise not complete",
        {rcv_complete, rcv_clear}, 0);
    @(negedge clk);
    chk(!rcv_done && !rcv_ack, "R4 no capture on partial", {rcv_done, rcv_ack}, 0);
    inj_t = 8'h3C; inj_f = 8'hC3;                 // complete 0x3C
    #1;
    chk(rcv_complete && !rcv_clear, "R4 complete word", {rcv_complete, rcv_clear}, 2);
    @(negedge clk);
    chk(rcv_done && rcv_ack && rcv_word == 8'h3C, "R7 capture 0x3C",
        {rcv_done, rcv_ack, rcv_word}, {2'b11, 8'h3C});
    @(negedge clk);
    chk(!rcv_done && rcv_ack, "R7 done one cycle", {rcv_done, rcv_ack}, 1);
    inj_t = 8'h30; inj_f = 8'hC0;                 // low four pairs lowered
    #1;
    chk(!rcv_clear && !rcv_complete, "R5 partial fall not cleared",
        {rcv_clear, rcv_complete}, 0);
    @(negedge clk);
    chk(rcv_ack && !rcv_done, "R5 ack held on partial fall", {rcv_ack, rcv_done}, 2);
    chk(rcv_ack, "R8 ack stays until cleared", rcv_ack, 1);
    inj_t = 8'h00; inj_f = 8'h00;
    @(negedge clk);
    chk(!rcv_ack, "R8 ack falls after clear", rcv_ack, 0);

    // complete pairs plus one shorted pair in the same cycle
    inj_t = 8'h8F; inj_f = 8'hF0;                 // pair 7 both high
    #1;
    chk(!rcv_complete && !rcv_clear, "R6 shorted pair flags",
        {rcv_complete, rcv_clear}, 0);
    @(negedge clk);
    chk(rcv_err && !rcv_done && !rcv_ack, "R6 error without capture",
        {rcv_err, rcv_done, rcv_ack}, 3'b100);
    inj_t = 8'h00; inj_f = 8'h00;
    repeat (2) @(negedge clk);
    chk(rcv_err, "R6 error sticky after clear", rcv_err, 1);
    inj_t = 8'h99; inj_f = 8'h66;
    @(negedge clk);
    chk(rcv_done && rcv_word == 8'h99 && rcv_err, "R7 capture after error",
        {rcv_done, rcv_word, rcv_err}, {1'b1, 8'h99, 1'b1});
    inj_t = 8'h00; inj_f = 8'h00;
    repeat (2) @(negedge clk);
    inject = 1'b0;

    reset_and_check();
    chk(!rcv_err, "R6 error cleared by reset", rcv_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule